// File: doc/BRIEF.md
# Three-Context Parallel CRC Calculator

This block computes cyclic redundancy checksums for three separate data streams at once. Each stream owns a private context: a configuration register, a running CRC state that software can seed, a write-only data input and a read-only result register. Software or a DMA master reaches all of them through one memory-mapped register port. Writes to different contexts may arrive in any interleaving, and no context ever sees another's traffic.

Each data write carries an access size of byte, half-word or word. The context folds exactly that many bits into its state in a single clock, most significant bit first. A single stream may therefore mix sizes freely. Three generators are selectable per context: CRC-32 (0x04C11DB7), CRC-CCITT (0x1021) and CRC-8 (0x1D). The result register presents the state after an optional bit reversal and an optional inversion. Every unused upper bit reads as zero.

Top module: `crc_multi_ctx`

## Requirements
- R1: After reset every context holds state 0xFFFFFFFF and configuration 0, and every result register reads 0xFFFFFFFF.
- R2: Context k (k = 0, 1, 2) occupies the byte addresses k*0x10 to k*0x10+0xF. Offset 0x0 is the configuration, 0x4 the state/seed, 0x8 the data input and 0xC the result. Address bits [1:0] are ignored. Addresses from 0x30 upward ignore writes and read as zero.
- R3: Configuration bits [1:0] select the generator: 00 gives CRC-32, 01 gives CCITT, 10 gives CRC-8 and 11 also gives CRC-32. Bit 2 enables the bit reversal and bit 3 enables the inversion. The register reads back these four bits with zeros above.
- R4: In CRC-32 mode the state advances over the written data, MSB first, in the same cycle as the write. With seed 0xFFFFFFFF and the bytes "123456789", the result reads 0x0376E6E7.
- R5: In CCITT mode only the low 16 state bits take part, and the result's upper 16 bits read zero. With seed 0xFFFF and "123456789", the result reads 0x000029B1.
- R6: In CRC-8 mode only the low 8 state bits take part, and the state's upper 24 bits are zero after any data write. With seed 0xFF, inversion on and "123456789", the result reads 0x0000004B.
- R7: The access size selects the bits consumed: 00 uses wdata[7:0], 01 uses wdata[15:0], and 10 or 11 uses wdata[31:0]. A stream that mixes sizes equals the same bytes sent one at a time.
- R8: A write to one context leaves the state, configuration and result of the other contexts unchanged. With no seed or data write, a context's state holds its value.
- R9: The bit reversal mirrors the active-width bits of the state. The inversion is applied after it and covers only those bits.
- R10: A read request returns data with rvalid_o high on the next cycle, and rvalid_o is low after any cycle without a read. Writes to the result register are ignored, and the data input reads zero.
- R11: A write to the state offset loads all 32 bits as a new seed, and reading that offset returns the raw state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Register access in this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| size_i | input | 2 | Data write size: 00 byte, 01 half-word, 1x word |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| rdata_o | output | 32 | Read data |

## Verification
The bench interleaves streams across all three contexts. A design that shared any state between contexts, or decoded the context index badly, would corrupt the neighbouring result. Known check values for all three generators catch a wrong polynomial, a wrong width mask or the wrong bit order. The same bytes are also sent as a word, a half-word and single bytes, so a design that took the wrong lanes for a size, or fed them LSB first, would diverge at once. The bench checks reversal and inversion in both orders. Long random runs also cover reserved generator codes, writes to the read-only result register and out-of-range addresses, where a sloppy decode would either corrupt a context or return stray data.

// File: rtl/crc_mc_pkg.sv
package crc_mc_pkg;

  typedef enum logic [1:0] {
    SEL_CRC32 = 2'd0,
    SEL_CCITT = 2'd1,
    SEL_CRC8  = 2'd2,
    SEL_ALT32 = 2'd3
  } poly_sel_e;

  typedef struct packed {
    logic      invert;
    logic      swap;
    poly_sel_e sel;
  } ctx_cfg_t;

  localparam int CFG_W = $bits(ctx_cfg_t);

  function automatic logic [31:0] gen_poly(poly_sel_e s);
    case (s)
      SEL_CCITT: return 32'h0000_1021;
      SEL_CRC8:  return 32'h0000_001D;
      default:   return 32'h04C1_1DB7;
    endcase
  endfunction

  function automatic logic [31:0] width_mask(poly_sel_e s);
    case (s)
      SEL_CCITT: return 32'h0000_FFFF;
      SEL_CRC8:  return 32'h0000_00FF;
      default:   return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [4:0] top_bit(poly_sel_e s);
    case (s)
      SEL_CCITT: return 5'd15;
      SEL_CRC8:  return 5'd7;
      default:   return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/crc_mc_step.sv
module crc_mc_step
  import crc_mc_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic [31:0]          state_i,
  input  logic [DATA_BITS-1:0] data_i,
  input  poly_sel_e            sel_i,
  output logic [31:0]          state_o
);

  always_comb begin
    logic [31:0] acc;
    logic [31:0] poly;
    logic [31:0] mask;
    logic [4:0]  msb;
    logic        fb;
    mask = width_mask(sel_i);
    poly = gen_poly(sel_i);
    msb  = top_bit(sel_i);
    acc  = state_i & mask;
    for (int i = DATA_BITS - 1; i >= 0; i--) begin
      fb  = acc[msb] ^ data_i[i];
      acc = (acc << 1) & mask;
      if (fb) acc = acc ^ poly;
    end
    state_o = acc;
  end

endmodule

// File: rtl/crc_mc_cond.sv
module crc_mc_cond
  import crc_mc_pkg::*;
(
  input  logic [31:0] state_i,
  input  ctx_cfg_t    cfg_i,
  output logic [31:0] out_o
);

  always_comb begin
    logic [31:0] mask;
    logic [31:0] kept;
    logic [31:0] rev;
    logic [31:0] picked;
    logic [4:0]  msb;
    logic [4:0]  src;
    mask = width_mask(cfg_i.sel);
    msb  = top_bit(cfg_i.sel);
    kept = state_i & mask;
    rev  = '0;
    for (int i = 0; i < 32; i++) begin
      src = msb - 5'(i);
      if (i <= int'(msb)) rev[i] = kept[src];
    end
    picked = cfg_i.swap ? rev : kept;
    out_o  = cfg_i.invert ? (picked ^ mask) : picked;
  end

endmodule

// File: rtl/crc_mc_ctx.sv
module crc_mc_ctx
  import crc_mc_pkg::*;
#(
  parameter int NUM_SIZES = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic        seed_we,
  input  logic        data_we,
  input  logic [1:0]  size_i,
  input  logic [31:0] wdata_i,
  output ctx_cfg_t    cfg_o,
  output logic [31:0] state_o,
  output logic [31:0] outp_o
);

  ctx_cfg_t    cfg_q, cfg_d;
  logic [31:0] state_q, state_d, outp_q, outp_d;
  logic [31:0] step_res [NUM_SIZES];

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_width
    localparam int BW = 8 << g;
    crc_mc_step #(.DATA_BITS(BW)) u_step (
      .state_i (state_q),
      .data_i  (wdata_i[BW-1:0]),
      .sel_i   (cfg_q.sel),
      .state_o (step_res[g])
    );
  end

  always_comb begin
    state_d = state_q;
    if (seed_we) begin
      state_d = wdata_i;
    end else if (data_we) begin
      case (size_i)
        2'b00:   state_d = step_res[0];
        2'b01:   state_d = step_res[1];
        default: state_d = step_res[NUM_SIZES-1];
      endcase
    end
    cfg_d = cfg_we ? ctx_cfg_t'(wdata_i[CFG_W-1:0]) : cfg_q;
  end

  crc_mc_cond u_cond (
    .state_i (state_d),
    .cfg_i   (cfg_d),
    .out_o   (outp_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '1;
      cfg_q   <= ctx_cfg_t'('0);
      outp_q  <= '1;
    end else begin
      state_q <= state_d;
      cfg_q   <= cfg_d;
      outp_q  <= outp_d;
    end
  end

  assign cfg_o   = cfg_q;
  assign state_o = state_q;
  assign outp_o  = outp_q;

  assert_reset_outp_R1: assert property (@(posedge clk)
    rst |=> (outp_q == 32'hFFFF_FFFF && state_q == 32'hFFFF_FFFF));

  assert_ccitt_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.sel == SEL_CCITT) |-> (outp_q[31:16] == 16'h0000));

  assert_crc8_narrow_R6: assert property (@(posedge clk) disable iff (rst)
    (data_we && cfg_q.sel == SEL_CRC8) |=> (state_q[31:8] == 24'h0));

  assert_idle_state_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (!seed_we && !data_we) |=> $stable(state_q));

endmodule

// File: rtl/crc_multi_ctx.sv
module crc_multi_ctx
  import crc_mc_pkg::*;
#(
  parameter int NUM_CTX = 3,
  parameter int ADDR_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  output logic              rvalid_o,
  output logic [31:0]       rdata_o
);

  localparam int OFF_LSB = 2;
  localparam int CTX_LSB = 4;
  localparam int IDX_W   = ADDR_W - CTX_LSB;
  localparam int OFF_W   = CTX_LSB - OFF_LSB;
  localparam logic [OFF_W-1:0] OFF_CFG  = 2'd0;
  localparam logic [OFF_W-1:0] OFF_SEED = 2'd1;
  localparam logic [OFF_W-1:0] OFF_DATA = 2'd2;
  localparam logic [OFF_W-1:0] OFF_OUTP = 2'd3;

  logic [IDX_W-1:0] idx;
  logic [OFF_W-1:0] off;
  logic             hit;
  logic             rd_req;
  logic             unused_addr_lsb;

  assign idx             = addr_i[ADDR_W-1:CTX_LSB];
  assign off             = addr_i[CTX_LSB-1:OFF_LSB];
  assign hit             = 32'(idx) < NUM_CTX;
  assign rd_req          = req_i && !we_i;
  assign unused_addr_lsb = ^addr_i[OFF_LSB-1:0];

  ctx_cfg_t    cfg_a   [NUM_CTX];
  logic [31:0] state_a [NUM_CTX];
  logic [31:0] outp_a  [NUM_CTX];

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    logic wsel;
    assign wsel = req_i && we_i && (idx == IDX_W'(c));
    crc_mc_ctx u_ctx (
      .clk     (clk),
      .rst     (rst),
      .cfg_we  (wsel && off == OFF_CFG),
      .seed_we (wsel && off == OFF_SEED),
      .data_we (wsel && off == OFF_DATA),
      .size_i  (size_i),
      .wdata_i (wdata_i),
      .cfg_o   (cfg_a[c]),
      .state_o (state_a[c]),
      .outp_o  (outp_a[c])
    );
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CTX; c++) begin
      if (idx == IDX_W'(c)) begin
        case (off)
          OFF_CFG:  rd_mux = {{(32-CFG_W){1'b0}}, cfg_a[c]};
          OFF_SEED: rd_mux = state_a[c];
          OFF_OUTP: rd_mux = outp_a[c];
          default:  rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_req;
      if (rd_req) rdata_o <= rd_mux;
    end
  end

  assert_rd_valid_R10: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rvalid_o);

  assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rvalid_o);

  assert_bad_addr_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !hit) |=> (rdata_o == 32'h0));

endmodule

// File: tb/test_crc_multi_ctx.sv
module test_crc_multi_ctx;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] wdata_i = '0;
  logic        rvalid_o;
  logic [31:0] rdata_o;

  always #10 clk = ~clk;

  crc_multi_ctx i_crc_multi_ctx (
    .clk(clk), .rst(rst), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .size_i(size_i), .wdata_i(wdata_i), .rvalid_o(rvalid_o), .rdata_o(rdata_o)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  string tag      = "R1";
  bit    done     = 0;

  // ---------------- behavioural reference ----------------
  logic [31:0] m_state [3];
  logic [3:0]  m_cfg   [3];
  logic        e_valid;
  logic [31:0] e_data;

  function automatic int ref_w(logic [1:0] sel);
    return (sel == 2'd1) ? 16 : (sel == 2'd2) ? 8 : 32;
  endfunction

  function automatic logic [32:0] ref_poly(logic [1:0] sel);
    return (sel == 2'd1) ? 33'h1021 : (sel == 2'd2) ? 33'h1D : 33'h04C11DB7;
  endfunction

  function automatic logic [32:0] ref_mask(int w);
    return (33'h1 << w) - 33'h1;
  endfunction

  // augmented-register form: inject the bit at the top, then reduce
  function automatic logic [31:0] ref_feed(logic [31:0] s, logic [31:0] d, int nbits, logic [1:0] sel);
    int w = ref_w(sel);
    logic [32:0] m = ref_mask(w);
    logic [32:0] a = {1'b0, s} & m;
    for (int k = nbits - 1; k >= 0; k--) begin
      a[w-1] = a[w-1] ^ d[k];
      if (a[w-1]) a = ((a << 1) ^ ref_poly(sel)) & m;
      else        a = (a << 1) & m;
    end
    return a[31:0];
  endfunction

  function automatic logic [31:0] ref_out(logic [31:0] s, logic [3:0] cfg);
    int w = ref_w(cfg[1:0]);
    logic [31:0] m = ref_mask(w)[31:0];
    logic [31:0] v = s & m;
    logic [31:0] r = '0;
    if (cfg[2]) begin
      for (int k = 0; k < w; k++) r[k] = v[w-1-k];
      v = r;
    end
    if (cfg[3]) v = v ^ m;
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 3; c++) begin
        m_state[c] = 32'hFFFFFFFF;
        m_cfg[c]   = 4'h0;
      end
      e_valid = 1'b0;
      e_data  = '0;
    end else begin
      int c;
      int o;
      c = addr_i[5:4];
      o = addr_i[3:2];
      e_valid = req_i && !we_i;
      if (req_i && !we_i) begin
        if (c > 2)       e_data = 32'h0;
        else if (o == 0) e_data = {28'h0, m_cfg[c]};
        else if (o == 1) e_data = m_state[c];
        else if (o == 3) e_data = ref_out(m_state[c], m_cfg[c]);
        else             e_data = 32'h0;
      end
      if (req_i && we_i && c <= 2) begin
        if (o == 0) m_cfg[c] = wdata_i[3:0];
        else if (o == 1) m_state[c] = wdata_i;
        else if (o == 2) begin
          int nb;
          nb = (size_i == 2'b00) ? 8 : (size_i == 2'b01) ? 16 : 32;
          m_state[c] = ref_feed(m_state[c], wdata_i, nb, m_cfg[c][1:0]);
        end
      end
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      n_checks++;
      if (rvalid_o !== e_valid || (e_valid && rdata_o !== e_data)) begin
        n_fail++;
        $display("FAIL %s: model mismatch valid=%b data=%h expected valid=%b data=%h",
                 tag, rvalid_o, rdata_o, e_valid, e_data);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic bus_wr(input logic [5:0] a, input logic [1:0] sz, input logic [31:0] d);
    req_i = 1; we_i = 1; addr_i = a; size_i = sz; wdata_i = d;
    @(negedge clk);
    req_i = 0; we_i = 0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    req_i = 1; we_i = 0; addr_i = a;
    @(negedge clk);
    req_i = 0;
    d = rdata_o;
  endtask

  task automatic rd_expect(input logic [5:0] a, input logic [31:0] exp, input string t);
    logic [31:0] got;
    tag = t;
    bus_rd(a, got);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: addr %h read %h expected %h", t, a, got, exp);
    end
  endtask

  task automatic send_digits_bytes(input logic [5:0] base);
    for (int k = 0; k < 9; k++) bus_wr(base + 6'h8, 2'b00, 32'h31 + k);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] dummy;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 / R2: reset values at every offset of every context
    for (int c = 0; c < 3; c++) begin
      rd_expect(6'(c*16 + 12), 32'hFFFFFFFF, "R1");
      rd_expect(6'(c*16 + 4),  32'hFFFFFFFF, "R1");
      rd_expect(6'(c*16 + 0),  32'h0,        "R3");
    end
    rd_expect(6'h3C, 32'h0, "R2");

    // R4: CRC-32 check value, byte by byte, in context 0
    tag = "R4";
    send_digits_bytes(6'h00);
    rd_expect(6'h0C, 32'h0376E6E7, "R4");

    // R5 R6 R7 R8: CCITT in ctx1 with mixed sizes interleaved with CRC-8 in ctx2
    bus_wr(6'h10, 2'b10, 32'h1);            // ctx1 CCITT
    bus_wr(6'h14, 2'b10, 32'h0000FFFF);     // R11 seed
    bus_wr(6'h20, 2'b10, 32'hA);            // ctx2 CRC-8 + invert
    bus_wr(6'h24, 2'b10, 32'hFF);
    rd_expect(6'h14, 32'h0000FFFF, "R11");
    rd_expect(6'h20, 32'h0000000A, "R3");
    tag = "R7";
    bus_wr(6'h18, 2'b10, 32'h31323334);     // word "1234"
    bus_wr(6'h28, 2'b00, 32'hAAAAAA31);     // byte '1', upper lanes ignored
    bus_wr(6'h18, 2'b01, 32'hDEAD3536);     // half "56"
    for (int k = 1; k < 9; k++) bus_wr(6'h28, 2'b00, 32'h31 + k);
    bus_wr(6'h18, 2'b00, 32'h37);
    bus_wr(6'h18, 2'b11, 32'h00383900);     // size 11 = word: consumes 00 38 39 00
    rd_expect(6'h2C, 32'h0000004B, "R6");
    rd_expect(6'h0C, 32'h0376E6E7, "R8");

    // R5: redo ctx1 with plain bytes to hit the check value
    bus_wr(6'h14, 2'b10, 32'hFFFFFFFF);
    rd_expect(6'h1C, 32'h0000FFFF, "R5");
    send_digits_bytes(6'h10);
    rd_expect(6'h1C, 32'h000029B1, "R5");

    // R7: same bytes as half-words and a word must match
    bus_wr(6'h14, 2'b10, 32'hFFFF);
    bus_wr(6'h18, 2'b01, 32'h3132);
    bus_wr(6'h18, 2'b10, 32'h33343536);
    bus_wr(6'h18, 2'b01, 32'h3738);
    bus_wr(6'h18, 2'b00, 32'h39);
    rd_expect(6'h1C, 32'h000029B1, "R7");

    // R9: reversal, then reversal plus inversion
    bus_wr(6'h00, 2'b10, 32'h4);
    rd_expect(6'h0C, 32'hE7676EC0, "R9");
    bus_wr(6'h00, 2'b10, 32'hC);
    rd_expect(6'h0C, 32'h1898913F, "R9");
    rd_expect(6'h04, 32'h0376E6E7, "R11");

    // R10: result register is read-only, input reads zero
    bus_wr(6'h0C, 2'b10, 32'h12345678);
    rd_expect(6'h0C, 32'h1898913F, "R10");
    rd_expect(6'h08, 32'h0, "R10");

    // R2: out-of-range writes leave every context alone
    bus_wr(6'h38, 2'b10, 32'h55);
    bus_wr(6'h34, 2'b10, 32'h0);
    rd_expect(6'h34, 32'h0, "R2");
    rd_expect(6'h04, 32'h0376E6E7, "R2");

    // R7 R8 R3: random interleaved traffic against the model
    tag = "R7";
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] a;
      a = 6'($urandom_range(0, 63));
      if ($urandom_range(0, 2) == 0) bus_rd(a, dummy);
      else if ($urandom_range(0, 3) != 0)
        bus_wr({a[5:4], 4'h8}, 2'($urandom_range(0, 3)), $urandom);
      else bus_wr(a, 2'($urandom_range(0, 3)), $urandom);
      if (n % 8 == 0) bus_rd({a[5:4], 4'hC}, dummy);
    end

    // R1: reset in the middle of traffic
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    for (int c = 0; c < 3; c++) rd_expect(6'(c*16 + 12), 32'hFFFFFFFF, "R1");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule